// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block sits between up to 64 interrupt request lines and one processor core. Each core has its own copy. Software gives every source a 4-bit priority, where 0 turns the source off. On every cycle the controller picks the pending source with the highest priority. When two or more pending sources share that priority, the lowest index wins. The controller raises its interrupt line only while the winner's priority is strictly above the current-priority register.

When the processor acknowledges, the controller does three things. It reports a 9-bit vector for the winning source, which is the source index zero-extended. It saves the old current priority on a 16-deep last-in-first-out stack. It lifts the current priority to the winner's level, so that only a strictly higher request can preempt the running handler. An end-of-interrupt command restores the last saved level. Software can also write the current priority directly. Raising it acts as a priority ceiling while a shared resource is in use.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0, vec_o is 0 and cur_prio_o is 0. Every source priority is 0, so requests alone raise no interrupt.
- R2: A source whose priority is 0 never wins arbitration and never causes irq_o to rise, whatever its request line does.
- R3: The winner is the pending enabled source with the highest priority. Among equal priorities, the lowest source index wins.
- R4: irq_o is a register. It is 1 one cycle after a cycle in which the winner's priority is strictly greater than the current priority. The winner is taken from the request lines and the stored priorities of that cycle. The current priority is the value that cycle leaves in place. An equal priority does not interrupt.
- R5: An acknowledge while irq_o is 1 does the following from the next cycle on. vec_o holds the winner's index, zero-extended to 9 bits. cur_prio_o holds the winner's priority. irq_o is evaluated against that new level. An acknowledge while irq_o is 0 has no effect.
- R6: Each accepted acknowledge pushes the old current priority onto a 16-entry stack. If the stack already holds 16 entries, the push is dropped, but the current priority is still raised.
- R7: An end-of-interrupt pops the stack into the current priority. With an empty stack it leaves the current priority unchanged.
- R8: A direct write loads the current priority. Raising it above a pending source's level masks that source. Lowering it lets the source interrupt again.
- R9: When commands arrive in the same cycle, an accepted acknowledge takes precedence over end-of-interrupt, and end-of-interrupt takes precedence over a direct write. The commands that lose have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 64 | Level request line per source |
| cfg_we_i | input | 1 | Write enable for a source priority |
| cfg_idx_i | input | 6 | Source index to configure |
| cfg_prio_i | input | 4 | Priority value to store (0 = off) |
| cur_we_i | input | 1 | Direct write of the current priority |
| cur_wdata_i | input | 4 | Value for the direct write |
| ack_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | End-of-interrupt command |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 9 | Vector of the last acknowledged source |
| cur_prio_o | output | 4 | Current priority level |

## Verification
Some properties are checked on every cycle:
- the arbiter's winner is always a requesting source with a nonzero priority;
- an accepted acknowledge always raises the current level;
- an acknowledge while irq_o is low leaves the level unchanged;
- an end-of-interrupt with an empty stack leaves the level unchanged;
- a push into a full stack leaves its fill count unchanged.

The remaining behaviours are shown only by the bench scenarios, which compare every output against a reference model on every step. These are the tie order among equal priorities, the value of each vector, the exact LIFO order of restored levels after the stack overflows, and the masking and unmasking done by ceiling writes.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_ACK  = 2'd1,
      CMD_EOI  = 2'd2,
      CMD_SET  = 2'd3
   } prio_cmd_e;
endpackage

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   localparam int IDX_W  = $clog2(NUM_SRC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        req,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   output logic                      win_valid,
   output logic [IDX_W-1:0]          win_idx,
   output logic [PRIO_W-1:0]         win_prio
);
   logic [PRIO_W-1:0] best_p;
   logic [IDX_W-1:0]  best_i;

   // scan from the top index down; ">=" lets a lower index take over a tie
   always_comb begin
      best_p = '0;
      best_i = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i] && (prio_flat[i*PRIO_W +: PRIO_W] != '0) &&
             (prio_flat[i*PRIO_W +: PRIO_W] >= best_p)) begin
            best_p = prio_flat[i*PRIO_W +: PRIO_W];
            best_i = IDX_W'(i);
         end
      end
   end

   assign win_valid = (best_p != '0);
   assign win_idx   = best_i;
   assign win_prio  = best_p;

   AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (req[win_idx] && (prio_flat[win_idx*PRIO_W +: PRIO_W] == win_prio) && (win_prio != '0))); // R2
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] top,
   output logic              empty,
   output logic              full
);
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_m1;

   assign empty  = (cnt_q == '0);
   assign full   = (cnt_q == CNT_W'(DEPTH));
   assign cnt_m1 = cnt_q - 1'b1;
   assign top    = empty ? '0 : mem_q[cnt_m1[PTR_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (push && !full) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (pop && !push && !empty) begin
         cnt_q <= cnt_m1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem_q[cnt_q[PTR_W-1:0]] <= din;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NUM_SRC     = 64,
   parameter int PRIO_W      = 4,
   parameter int VEC_W       = 9,
   parameter int STACK_DEPTH = 16,
   localparam int IDX_W      = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               cfg_we_i,
   input  logic [IDX_W-1:0]   cfg_idx_i,
   input  logic [PRIO_W-1:0]  cfg_prio_i,
   input  logic               cur_we_i,
   input  logic [PRIO_W-1:0]  cur_wdata_i,
   input  logic               ack_i,
   input  logic               eoi_i,
   output logic               irq_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic [PRIO_W-1:0]  cur_prio_o
);
   import prio_irq_pkg::*;

   initial begin
      assert (NUM_SRC >= 2) else $error("NUM_SRC must be at least 2");
      assert (VEC_W >= IDX_W) else $error("VEC_W too narrow for NUM_SRC");
      assert (STACK_DEPTH >= 2) else $error("STACK_DEPTH must be at least 2");
      assert (PRIO_W >= 1) else $error("PRIO_W must be at least 1");
   end

   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic                      win_valid;
   logic [IDX_W-1:0]          win_idx;
   logic [PRIO_W-1:0]         win_prio;
   logic                      irq_q;
   logic [IDX_W-1:0]          widx_q;
   logic [PRIO_W-1:0]         wprio_q;
   logic [VEC_W-1:0]          vec_q;
   logic [PRIO_W-1:0]         cur_q, cur_nxt;
   logic [PRIO_W-1:0]         stk_top;
   logic                      stk_empty, stk_full;
   prio_cmd_e                 cmd;

   // per-source priority registers
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic [PRIO_W-1:0] prio_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      prio_q <= '0;
         else if (cfg_we_i && (cfg_idx_i == IDX_W'(g)))   prio_q <= cfg_prio_i;
      end
      assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
   end

   prio_irq_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req_i), .prio_flat(prio_flat),
      .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
   );

   // one command per cycle: accepted ack, then eoi, then direct write
   always_comb begin
      if (ack_i && irq_q) cmd = CMD_ACK;
      else if (eoi_i)     cmd = CMD_EOI;
      else if (cur_we_i)  cmd = CMD_SET;
      else                cmd = CMD_NONE;
   end

   always_comb begin
      unique case (cmd)
         CMD_ACK: cur_nxt = wprio_q;
         CMD_EOI: cur_nxt = stk_empty ? cur_q : stk_top;
         CMD_SET: cur_nxt = cur_wdata_i;
         default: cur_nxt = cur_q;
      endcase
   end

   prio_irq_stack #(.DEPTH(STACK_DEPTH), .DATA_W(PRIO_W)) u_stack (
      .clk(clk), .rst_n(rst_n),
      .push(cmd == CMD_ACK), .pop(cmd == CMD_EOI), .din(cur_q),
      .top(stk_top), .empty(stk_empty), .full(stk_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= '0;
         irq_q   <= 1'b0;
         widx_q  <= '0;
         wprio_q <= '0;
         vec_q   <= '0;
      end else begin
         cur_q   <= cur_nxt;
         irq_q   <= win_valid && (win_prio > cur_nxt);
         widx_q  <= win_idx;
         wprio_q <= win_prio;
         if (cmd == CMD_ACK) vec_q <= VEC_W'(widx_q);
      end
   end

   assign irq_o      = irq_q;
   assign vec_o      = vec_q;
   assign cur_prio_o = cur_q;

   AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> (cur_prio_o > $past(cur_prio_o))); // R5
   AST_ACK_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !irq_o && !eoi_i && !cur_we_i) |=> $stable(cur_prio_o)); // R5
   AST_EOI_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_i && !(ack_i && irq_o) && stk_empty) |=> $stable(cur_prio_o)); // R7
   AST_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && stk_full) |=> (cur_prio_o == $past(wprio_q))); // R6
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
   localparam int NS = 64;
   localparam int SD = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NS-1:0] req = '0;
   logic          cfg_we = 1'b0;
   logic [5:0]    cfg_idx = '0;
   logic [3:0]    cfg_prio = '0;
   logic          cur_we = 1'b0;
   logic [3:0]    cur_wdata = '0;
   logic          ack = 1'b0;
   logic          eoi = 1'b0;
   logic          irq;
   logic [8:0]    vec;
   logic [3:0]    curp;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
      .cfg_prio_i(cfg_prio), .cur_we_i(cur_we), .cur_wdata_i(cur_wdata),
      .ack_i(ack), .eoi_i(eoi), .irq_o(irq), .vec_o(vec), .cur_prio_o(curp)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   // reference model state
   int mprio [NS];
   int mstk [SD];
   int mcnt = 0;
   int mcur = 0;
   int mvec = 0;
   int mwidx = 0;
   int mwprio = 0;
   bit mirq = 1'b0;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int best_idx(logic [NS-1:0] r);
      int bi = 0, bp = 0;
      for (int i = 0; i < NS; i++)
         if (r[i] && mprio[i] != 0 && mprio[i] > bp) begin bp = mprio[i]; bi = i; end
      return bi;
   endfunction

   function automatic int best_prio(logic [NS-1:0] r);
      int bp = 0;
      for (int i = 0; i < NS; i++)
         if (r[i] && mprio[i] > bp) bp = mprio[i];
      return bp;
   endfunction

   task automatic model_update();
      int bi, bp;
      if (ack && mirq) begin
         mvec = mwidx;
         if (mcnt < SD) begin mstk[mcnt] = mcur; mcnt++; end
         mcur = mwprio;
      end else if (eoi) begin
         if (mcnt > 0) begin mcnt--; mcur = mstk[mcnt]; end
      end else if (cur_we) begin
         mcur = int'(cur_wdata);
      end
      bi = best_idx(req);
      bp = best_prio(req);
      mirq = (bp != 0) && (bp > mcur);
      mwidx = bi;
      mwprio = bp;
      if (cfg_we) mprio[cfg_idx] = int'(cfg_prio);
   endtask

   // inputs are set at a falling edge; outputs compared at the next falling edge
   task automatic step(string tag);
      model_update();
      @(posedge clk);
      @(negedge clk);
      chk(tag, "irq", int'(irq), int'(mirq));
      chk(tag, "vec", int'(vec), mvec);
      chk(tag, "cur", int'(curp), mcur);
      cfg_we = 1'b0; ack = 1'b0; eoi = 1'b0; cur_we = 1'b0;
   endtask

   task automatic set_prio(int idx, int p, string tag);
      cfg_we = 1'b1; cfg_idx = 6'(idx); cfg_prio = 4'(p);
      step(tag);
   endtask

   task automatic set_cur(int v, string tag);
      cur_we = 1'b1; cur_wdata = 4'(v);
      step(tag);
   endtask

   task automatic do_ack(string tag);
      ack = 1'b1;
      step(tag);
   endtask

   task automatic do_eoi(string tag);
      eoi = 1'b1;
      step(tag);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NS; i++) mprio[i] = 0;
      repeat (3) @(negedge clk);
      chk("R1", "irq in reset", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "irq", int'(irq), 0);
      chk("R1", "vec", int'(vec), 0);
      chk("R1", "cur", int'(curp), 0);

      // R1: every line requesting, no priority programmed
      req = '1;
      step("R1");
      step("R1");
      chk("R1", "irq idle all req", int'(irq), 0);

      // R2: an explicitly disabled source stays silent
      req = '0;
      req[5] = 1'b1;
      set_prio(5, 0, "R2");
      step("R2");
      chk("R2", "irq disabled src", int'(irq), 0);

      // R3: tie at priority 7 between sources 3 and 10
      req = '0;
      set_prio(10, 7, "R3");
      set_prio(3, 7, "R3");
      set_prio(40, 9, "R3");
      req[3] = 1'b1; req[10] = 1'b1;
      step("R3");
      step("R3");
      do_ack("R3");
      chk("R3", "tie vector", int'(vec), 3);
      do_eoi("R7");
      req[40] = 1'b1;
      step("R3");
      step("R3");
      do_ack("R3");
      chk("R3", "highest vector", int'(vec), 40);
      chk("R5", "level raised", int'(curp), 9);
      do_eoi("R7");
      chk("R7", "restored level", int'(curp), 0);

      // R4 / R8: strict comparison and ceiling writes
      req = '0; req[10] = 1'b1;
      set_cur(7, "R8");
      step("R4");
      chk("R4", "equal level no irq", int'(irq), 0);
      set_cur(6, "R8");
      chk("R8", "lowered ceiling irq", int'(irq), 1);
      set_cur(12, "R8");
      chk("R8", "raised ceiling mask", int'(irq), 0);
      do_ack("R5");
      chk("R5", "ack while idle cur", int'(curp), 12);
      set_cur(0, "R8");

      // R9: accepted ack beats a simultaneous eoi and write
      ack = 1'b1; eoi = 1'b1; cur_we = 1'b1; cur_wdata = 4'd2;
      step("R9");
      chk("R9", "ack precedence", int'(curp), 7);
      do_eoi("R7");

      // R6: overflow the stack with 17 nested acknowledges
      req = '0; req[0] = 1'b1;
      set_prio(0, 15, "R6");
      for (int k = 0; k < 17; k++) begin
         set_cur(k % 15, "R6");
         do_ack("R6");
      end
      for (int k = 0; k < 17; k++) do_eoi("R6");
      do_eoi("R7");
      chk("R7", "empty pop", int'(curp), mcur);

      // constrained random phase
      req = '0;
      for (int n = 0; n < 4000; n++) begin
         int op;
         op = int'($urandom % 16);
         if (($urandom % 8) == 0) req = {$urandom, $urandom} & {$urandom, $urandom};
         if (op < 3) begin
            cfg_we = 1'b1; cfg_idx = 6'($urandom); cfg_prio = 4'($urandom);
         end
         if (op >= 3 && op < 8) ack = 1'b1;
         if (op >= 7 && op < 10) eoi = 1'b1;
         if (op == 10 || op == 8) begin cur_we = 1'b1; cur_wdata = 4'($urandom % 6); end
         step("R4");
      end

      finish_run();
   end
endmodule